// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns eight already-synchronized input lines into interrupt requests. Each line has its own sensing choice: active-high level, active-low level, rising edge, falling edge or any transition. The configuration arrives as four vectors with one bit per line: level select, any-transition select, polarity and enable. A write-one-to-clear pulse vector comes from the register block that wraps this detector. Bus decoding and register storage live in that wrapper.

Level-sensed lines report status straight from the pin. Edge-sensed lines capture the event in a per-line two-state machine. The states are `LAT_IDLE` and `LAT_HELD`. The capture transition (`LAT_IDLE` to `LAT_HELD`) fires on a qualifying edge. The release transition (`LAT_HELD` to `LAT_IDLE`) fires on a clear pulse with no new edge in the same cycle. The discard transition (`LAT_HELD` to `LAT_IDLE`) fires whenever the line is switched to level sensing.

Edges are found by comparing each line with its value one cycle earlier. Raw status is ANDed with the enable vector to form masked status. The single interrupt output is the OR of the masked bits.

Top module: `gpio_irq_detect`

## Requirements
- R1: With level select 1 and polarity 1, raw status bit n equals pin n in the same cycle, with no register in between.
- R2: With level select 1 and polarity 0, raw status bit n equals the inverse of pin n in the same cycle.
- R3: With level select 0, any-transition 0 and polarity 1, a 0-to-1 change of pin n between two clock edges sets raw status bit n from the following clock edge on.
- R4: With level select 0, any-transition 0 and polarity 0, a 1-to-0 change of pin n sets raw status bit n from the following clock edge on.
- R5: With level select 0 and any-transition 1, either change of pin n sets raw status bit n, whatever the polarity bit.
- R6: A set edge status bit stays set until a clock edge at which clear bit n is 1. A clear bit of 0 leaves the status bit unchanged.
- R7: A level status bit ignores the clear vector and drops as soon as the pin leaves its active level.
- R8: If a qualifying edge and clear bit n occur in the same cycle, the status bit ends set.
- R9: Masked status equals raw status AND enable. Raw status is updated for lines whose enable bit is 0.
- R10: The interrupt output is 1 exactly when at least one masked status bit is 1.
- R11: After reset all edge status bits are 0, and the stored previous pin values are 0.
- R12: While a line is in level sensing, any captured edge is discarded. After the line returns to edge sensing, raw status reads 0 until a new edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPIN | Synchronized pin values |
| lvl_sel_i | input | NPIN | 1 = level sensing, 0 = edge sensing |
| any_edge_i | input | NPIN | 1 = any transition triggers (edge sensing only) |
| polarity_i | input | NPIN | Level: 1 high / 0 low. Edge: 1 rising / 0 falling |
| enable_i | input | NPIN | Interrupt enable mask |
| clear_i | input | NPIN | Write-one-to-clear pulse, one cycle per write |
| raw_o | output | NPIN | Raw status |
| masked_o | output | NPIN | Raw status AND enable |
| irq_o | output | 1 | OR of masked status |

## Verification
The bench places a clear and a rising edge in the same cycle. A design where the clear takes priority would lose that event and read 0 where 1 is expected. It also flips a line with a captured edge into level mode and back. A design that keeps the stale capture would raise a phantom interrupt. Clears are sent to level-sensed lines, where a design that latches level status would fail to follow the pin. Random traffic on lines with their enable bit cleared shows whether raw status wrongly depends on the mask.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_HELD = 1'b1
    } lat_state_e;
endpackage

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] any_edge_i,
    input  logic [NPIN-1:0] polarity_i,
    output logic [NPIN-1:0] hit_o
);
    logic [NPIN-1:0] pin_q;

    // one-cycle delayed copy of the pins, cleared by reset (R11)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_i;
    end

    for (genvar n = 0; n < NPIN; n++) begin : g_hit
        logic rise, fall;
        assign rise = pin_i[n] & ~pin_q[n];
        assign fall = ~pin_i[n] & pin_q[n];
        assign hit_o[n] = any_edge_i[n] ? (rise | fall)
                        : (polarity_i[n] ? rise : fall);
    end
endmodule

// File: rtl/gpio_pin_latch.sv
module gpio_pin_latch
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic lvl_i,
    input  logic pol_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic raw_o
);
    lat_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            LAT_IDLE: if (!lvl_i && hit_i) state_nxt = LAT_HELD;            // capture
            LAT_HELD: if (lvl_i)           state_nxt = LAT_IDLE;            // discard
                      else if (clr_i && !hit_i) state_nxt = LAT_IDLE;       // release
            default:  state_nxt = LAT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LAT_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        if (lvl_i) raw_o = (pin_i == pol_i);
        else       raw_o = (state == LAT_HELD);
    end

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_i && hit_i) |=> (state == LAT_HELD));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LAT_HELD && !clr_i && !lvl_i) |=> (state == LAT_HELD));
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LAT_HELD && clr_i && !hit_i && !lvl_i) |=> (state == LAT_IDLE));
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && hit_i && !lvl_i) |=> (state == LAT_HELD));
    assert_discard_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_i |=> (state == LAT_IDLE));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] lvl_sel_i,
    input  logic [NPIN-1:0] any_edge_i,
    input  logic [NPIN-1:0] polarity_i,
    input  logic [NPIN-1:0] enable_i,
    input  logic [NPIN-1:0] clear_i,
    output logic [NPIN-1:0] raw_o,
    output logic [NPIN-1:0] masked_o,
    output logic            irq_o
);
    logic [NPIN-1:0] hit;

    gpio_edge_sense #(.NPIN(NPIN)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .any_edge_i (any_edge_i),
        .polarity_i (polarity_i),
        .hit_o      (hit)
    );

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
        gpio_pin_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_i[n]),
            .lvl_i (lvl_sel_i[n]),
            .pol_i (polarity_i[n]),
            .hit_i (hit[n]),
            .clr_i (clear_i[n]),
            .raw_o (raw_o[n])
        );
    end

    assign masked_o = raw_o & enable_i;
    assign irq_o    = |masked_o;

    // R10: no interrupt while every enable bit is off
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i == '0) |-> !irq_o);
    // R7: a level-sensed line follows its pin after the cycle, whatever clear did
    assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel_i[0] && $stable(lvl_sel_i[0]) && $stable(polarity_i[0]) && $stable(pin_i[0]))
        |-> (raw_o[0] == (pin_i[0] == polarity_i[0])));
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
    localparam int N = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin = '0, lvl = '0, anye = '0, pol = '0, en = '0, clr = '0;
    logic [N-1:0] raw, masked;
    logic irq;
    int checks = 0, fails = 0;

    // behavioural reference state
    bit held [N];
    bit prev [N];

    always #5 clk = ~clk;

    gpio_irq_detect #(.NPIN(N)) u_gpio_irq_detect (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .lvl_sel_i(lvl), .any_edge_i(anye),
        .polarity_i(pol), .enable_i(en), .clear_i(clr),
        .raw_o(raw), .masked_o(masked), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input int n);
        if (lvl[n]) return pol[n] ? "R1" : "R2";
        if (anye[n]) return "R5";
        return pol[n] ? "R3" : "R4";
    endfunction

    function automatic logic [N-1:0] model_raw();
        logic [N-1:0] r;
        for (int n = 0; n < N; n++)
            r[n] = lvl[n] ? (pin[n] == pol[n]) : held[n];
        return r;
    endfunction

    // compare now, then advance model and design over one clock edge
    task automatic cyc();
        logic [N-1:0] er;
        bit nh [N];
        #1;
        er = model_raw();
        for (int n = 0; n < N; n++) chk(mode_tag(n), {7'b0, raw[n]}, {7'b0, er[n]});
        chk("R9", masked, er & en);
        chk("R10", {7'b0, irq}, {7'b0, |(er & en)});
        for (int n = 0; n < N; n++) begin
            bit h;
            h = anye[n] ? (pin[n] != prev[n])
              : (pol[n] ? (pin[n] && !prev[n]) : (!pin[n] && prev[n]));
            if (lvl[n])      nh[n] = 1'b0;
            else if (h)      nh[n] = 1'b1;
            else if (clr[n]) nh[n] = 1'b0;
            else             nh[n] = held[n];
        end
        @(posedge clk);
        for (int n = 0; n < N; n++) begin
            held[n] = nh[n];
            prev[n] = pin[n];
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int n = 0; n < N; n++) begin held[n] = 0; prev[n] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11", raw, '0);
        chk("R11", {7'b0, irq}, 8'h0);
        @(negedge clk);

        // mixed configuration: 0 lvl-hi, 1 lvl-lo, 2 rise, 3 fall, 4 any, 5 rise, 6 any, 7 lvl-hi
        lvl  = 8'b1000_0011;
        pol  = 8'b1010_0101;
        anye = 8'b0101_0000;
        en   = 8'b1111_1111;
        cyc();
        pin = 8'hFF; cyc();
        pin = 8'h00; cyc();
        chk("R3", {7'b0, raw[2]}, 8'h1);
        chk("R4", {7'b0, raw[3]}, 8'h1);
        chk("R5", {7'b0, raw[4]}, 8'h1);
        clr = 8'hFF; cyc(); clr = '0;
        chk("R6", raw & 8'b0111_1100, '0);
        chk("R7", {7'b0, raw[1]}, 8'h1);   // level-low pin at 0 ignores clear

        // R8: rising edge on pin 2 in the same cycle as its clear
        pin[2] = 1'b1; clr[2] = 1'b1; cyc(); clr = '0;
        chk("R8", {7'b0, raw[2]}, 8'h1);
        // R6: clear bit 0 leaves it set
        cyc();
        chk("R6", {7'b0, raw[2]}, 8'h1);

        // R12: capture on pin 5, flip to level and back
        pin[5] = 1'b1; cyc();
        chk("R3", {7'b0, raw[5]}, 8'h1);
        lvl[5] = 1'b1; cyc();
        lvl[5] = 1'b0; cyc();
        chk("R12", {7'b0, raw[5]}, 8'h0);

        // R9: disabled lines still record raw status
        en = 8'b0000_0001; pin[6] = 1'b1; cyc();
        chk("R9", {7'b0, raw[6]}, 8'h1);
        chk("R9", {7'b0, masked[6]}, 8'h0);

        // random traffic with occasional reconfiguration
        for (int i = 0; i < 400; i++) begin
            pin = N'($urandom);
            clr = (($urandom % 4) == 0) ? N'($urandom) : '0;
            if ((i % 50) == 0) begin
                lvl = N'($urandom); pol = N'($urandom);
                anye = N'($urandom); en = N'($urandom);
            end
            cyc();
        end
        clr = '0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule